// File: doc/BRIEF.md
# Cartridge GPIO Port Registers

This block is a small memory-mapped general-purpose I/O port with four pins, placed in the cartridge address window. It holds three registers: a pin-state register, a per-pin direction register, and a one-bit enable that gates every read. Software reaches them with halfword and byte accesses at three fixed addresses. A word write that covers two neighbouring registers is split between them.

A direction bit of 1 makes the pin an output. A pin-state write keeps only the output pins. A pin-state read shows only the input pins. Each pin-state write is also passed on as a one-cycle strobe with a four-bit payload, for a serial device attached to the pins. That device is not part of this block.

Each access lasts one cycle and is described by valid, write, size, address and write data. Read data comes back registered one cycle later, together with a hit flag.

Top module: `cart_gpio_port`

## Requirements
- R1: After reset the pin-state register is 0000, the direction register is 1111 and the enable bit is 0. `rd_hit` and `pin_stb` are low.
- R2: While the enable bit is 0, a read of any port register still raises `rd_hit`, but `rd_data` is 0.
- R3: While enabled, a pin-state read returns the stored pin state ANDed with the inverse of the direction register. A direction read returns the direction nibble. An enable read returns the enable bit in bit 0.
- R4: A halfword write at `BASE+0xC4` stores `wdata[3:0]` ANDed with the direction value held before the access. In the next cycle `pin_stb` is high for exactly one cycle and `pin_val` carries that masked value.
- R5: A halfword write at `BASE+0xC6` loads direction from `wdata[3:0]`. A halfword write at `BASE+0xC8` loads the enable bit from `wdata[0]`. Neither write pulses `pin_stb`.
- R6: A word write at `BASE+0xC4` updates the pin state from `wdata[3:0]`, masked as in R4 with the old direction, and pulses the strobe. In the same access it loads direction from `wdata[19:16]`.
- R7: A word write at `BASE+0xC6` loads direction from `wdata[3:0]` and the enable bit from `wdata[16]`.
- R8: Byte writes (`acc_size`=0) to any port address change no register and raise no strobe.
- R9: Accesses to other addresses change no register and raise neither `rd_hit` nor `pin_stb`. The same holds for word reads (`acc_size`=2) at any port address and for a word write at `BASE+0xC8`.
- R10: A halfword (`acc_size`=1) or byte read at a port address raises `rd_hit` in the following cycle, with the value in `rd_data` zero-extended. `rd_data` is 0 whenever `rd_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_addr | input | 32 | Byte address of the access |
| acc_wdata | input | 32 | Write data |
| rd_hit | output | 1 | A port register was read in the previous cycle |
| rd_data | output | 16 | Registered read value, zero when no hit |
| pin_stb | output | 1 | One-cycle pin-update strobe for the attached device |
| pin_val | output | 4 | Masked pin value carried by the strobe |

## Verification
The assertions assume at most one access per cycle. They also assume `acc_size` never takes the value 3, and that inputs are stable around the clock edge.

The bench drives every access on the falling edge for exactly one cycle, and draws sizes only from 0, 1 and 2. Its random addresses mix the three register addresses with neighbouring, odd and foreign addresses, so decode misses and ignored sizes are exercised all through the run.

// File: rtl/cart_gpio_pkg.sv
package cart_gpio_pkg;
  localparam int PIN_W   = 4;
  localparam int RD_W    = 16;
  localparam int ADDR_W  = 32;
  localparam int WDATA_W = 32;
  localparam int HI_LANE = 16;

  localparam logic [ADDR_W-1:0] OFS_PINS = 32'h0000_00C4;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 32'h0000_00C6;
  localparam logic [ADDR_W-1:0] OFS_EN   = 32'h0000_00C8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    SEL_PINS = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;

  // Keep only the pins configured as outputs.
  function automatic logic [PIN_W-1:0] keep_outputs(input logic [PIN_W-1:0] v,
                                                     input logic [PIN_W-1:0] dir);
    return v & dir;
  endfunction

  // Show only the pins configured as inputs.
  function automatic logic [PIN_W-1:0] show_inputs(input logic [PIN_W-1:0] v,
                                                    input logic [PIN_W-1:0] dir);
    return v & ~dir;
  endfunction
endpackage

// File: rtl/cart_gpio_decode.sv
module cart_gpio_decode
  import cart_gpio_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE = 32'h0800_0000
) (
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [1:0]         acc_size,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [WDATA_W-1:0] acc_wdata,
  output logic               wr_pins_en,
  output logic [PIN_W-1:0]   wr_pins_v,
  output logic               wr_dir_en,
  output logic [PIN_W-1:0]   wr_dir_v,
  output logic               wr_en_en,
  output logic               wr_en_v,
  output logic               rd_en,
  output reg_sel_e           rd_sel,
  output logic               port_hit
);
  logic hit_pins, hit_dir, hit_en;

  assign hit_pins = (acc_addr == BASE + OFS_PINS);
  assign hit_dir  = (acc_addr == BASE + OFS_DIR);
  assign hit_en   = (acc_addr == BASE + OFS_EN);
  assign port_hit = hit_pins | hit_dir | hit_en;

  always_comb begin
    wr_pins_en = 1'b0;
    wr_pins_v  = '0;
    wr_dir_en  = 1'b0;
    wr_dir_v   = '0;
    wr_en_en   = 1'b0;
    wr_en_v    = 1'b0;
    rd_en      = 1'b0;
    rd_sel     = SEL_PINS;
    if (acc_valid && acc_write) begin
      if (acc_size == SZ_HALF) begin
        if (hit_pins) begin
          wr_pins_en = 1'b1;
          wr_pins_v  = acc_wdata[PIN_W-1:0];
        end
        if (hit_dir) begin
          wr_dir_en = 1'b1;
          wr_dir_v  = acc_wdata[PIN_W-1:0];
        end
        if (hit_en) begin
          wr_en_en = 1'b1;
          wr_en_v  = acc_wdata[0];
        end
      end else if (acc_size == SZ_WORD) begin
        if (hit_pins) begin
          wr_pins_en = 1'b1;
          wr_pins_v  = acc_wdata[PIN_W-1:0];
          wr_dir_en  = 1'b1;
          wr_dir_v   = acc_wdata[HI_LANE +: PIN_W];
        end
        if (hit_dir) begin
          wr_dir_en = 1'b1;
          wr_dir_v  = acc_wdata[PIN_W-1:0];
          wr_en_en  = 1'b1;
          wr_en_v   = acc_wdata[HI_LANE];
        end
      end
    end else if (acc_valid && (acc_size == SZ_HALF || acc_size == SZ_BYTE) && port_hit) begin
      rd_en  = 1'b1;
      rd_sel = hit_pins ? SEL_PINS : (hit_dir ? SEL_DIR : SEL_EN);
    end
  end
endmodule

// File: rtl/cart_gpio_regs.sv
module cart_gpio_regs
  import cart_gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pins_en,
  input  logic [PIN_W-1:0] wr_pins_v,
  input  logic             wr_dir_en,
  input  logic [PIN_W-1:0] wr_dir_v,
  input  logic             wr_en_en,
  input  logic             wr_en_v,
  output logic [PIN_W-1:0] pins_q,
  output logic [PIN_W-1:0] dir_q,
  output logic             en_q,
  output logic             pin_stb,
  output logic [PIN_W-1:0] pin_val
);
  logic [PIN_W-1:0] pins_next;

  // Mask with the direction held before this access.
  assign pins_next = keep_outputs(wr_pins_v, dir_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q  <= '0;
      dir_q   <= '1;
      en_q    <= 1'b0;
      pin_stb <= 1'b0;
      pin_val <= '0;
    end else begin
      pin_stb <= wr_pins_en;
      if (wr_pins_en) begin
        pins_q  <= pins_next;
        pin_val <= pins_next;
      end
      if (wr_dir_en) dir_q <= wr_dir_v;
      if (wr_en_en)  en_q  <= wr_en_v;
    end
  end

  AST_STB_OUTPUTS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pin_stb |-> ((pin_val & ~$past(dir_q)) == '0)); // R4
  AST_STB_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_stb |-> $past(wr_pins_en)); // R4
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_stb && !$past(wr_pins_en, 2)) |=> (!pin_stb || $past(wr_pins_en))); // R4
endmodule

// File: rtl/cart_gpio_rdport.sv
module cart_gpio_rdport
  import cart_gpio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  reg_sel_e         rd_sel,
  input  logic [PIN_W-1:0] pins_q,
  input  logic [PIN_W-1:0] dir_q,
  input  logic             en_q,
  output logic             rd_hit,
  output logic [RD_W-1:0]  rd_data
);
  logic [RD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (en_q) begin
      unique case (rd_sel)
        SEL_PINS: rd_mux = RD_W'(show_inputs(pins_q, dir_q));
        SEL_DIR:  rd_mux = RD_W'(dir_q);
        SEL_EN:   rd_mux = RD_W'(en_q);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_hit  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_hit  <= rd_en;
      rd_data <= rd_en ? rd_mux : '0;
    end
  end

  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> ($past(en_q) || rd_data == '0)); // R2
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == '0)); // R10
  AST_RD_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (rd_data[RD_W-1:PIN_W] == '0)); // R10
endmodule

// File: rtl/cart_gpio_port.sv
module cart_gpio_port
  import cart_gpio_pkg::*;
#(
  parameter logic [31:0] BASE = 32'h0800_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_size,
  input  logic [31:0] acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        rd_hit,
  output logic [15:0] rd_data,
  output logic        pin_stb,
  output logic [3:0]  pin_val
);
  logic             wr_pins_en, wr_dir_en, wr_en_en, wr_en_v;
  logic [PIN_W-1:0] wr_pins_v, wr_dir_v;
  logic             rd_en, port_hit;
  reg_sel_e         rd_sel;
  logic [PIN_W-1:0] pins_q, dir_q;
  logic             en_q;

  cart_gpio_decode #(.BASE(BASE)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_size  (acc_size),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .wr_pins_en(wr_pins_en),
    .wr_pins_v (wr_pins_v),
    .wr_dir_en (wr_dir_en),
    .wr_dir_v  (wr_dir_v),
    .wr_en_en  (wr_en_en),
    .wr_en_v   (wr_en_v),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .port_hit  (port_hit)
  );

  cart_gpio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_pins_en(wr_pins_en),
    .wr_pins_v (wr_pins_v),
    .wr_dir_en (wr_dir_en),
    .wr_dir_v  (wr_dir_v),
    .wr_en_en  (wr_en_en),
    .wr_en_v   (wr_en_v),
    .pins_q    (pins_q),
    .dir_q     (dir_q),
    .en_q      (en_q),
    .pin_stb   (pin_stb),
    .pin_val   (pin_val)
  );

  cart_gpio_rdport u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_sel (rd_sel),
    .pins_q (pins_q),
    .dir_q  (dir_q),
    .en_q   (en_q),
    .rd_hit (rd_hit),
    .rd_data(rd_data)
  );

  AST_BYTE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_size == SZ_BYTE)
      |=> ($stable(pins_q) && $stable(dir_q) && $stable(en_q) && !pin_stb)); // R8
  AST_MISS_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !port_hit)
      |=> ($stable(pins_q) && $stable(dir_q) && $stable(en_q) && !pin_stb && !rd_hit)); // R9
  AST_WORD_RD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_size == SZ_WORD) |=> !rd_hit); // R9
  AST_PINS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pins_en |=> ((pins_q & ~$past(dir_q)) == '0)); // R4
endmodule

// File: tb/cart_gpio_port_tb_top.sv
module cart_gpio_port_tb_top;
  localparam logic [31:0] BASE = 32'h0800_0000;
  localparam logic [31:0] A_PINS = BASE + 32'hC4;
  localparam logic [31:0] A_DIR  = BASE + 32'hC6;
  localparam logic [31:0] A_EN   = BASE + 32'hC8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [1:0]  acc_size = 2'd0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        rd_hit, pin_stb;
  logic [15:0] rd_data;
  logic [3:0]  pin_val;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // Bench view of the port state, kept from the requirements.
  logic [3:0] m_pins, m_dir;
  logic       m_en;

  always #2.5 clk = ~clk;

  cart_gpio_port #(.BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_hit(rd_hit), .rd_data(rd_data), .pin_stb(pin_stb), .pin_val(pin_val)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [31:0] a);
    if (!m_en) return 16'h0;                       // R2
    if (a == A_PINS) return {12'h0, m_pins & ~m_dir}; // R3
    if (a == A_DIR)  return {12'h0, m_dir};
    return {15'h0, m_en};
  endfunction

  function automatic bit is_port(input logic [31:0] a);
    return (a == A_PINS) || (a == A_DIR) || (a == A_EN);
  endfunction

  task automatic do_op(input logic w, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] wd);
    logic        e_hit, e_stb;
    logic [15:0] e_rd;
    logic [3:0]  e_pv, n_pins, n_dir;
    logic        n_en;
    string       tag;
    e_hit = 0; e_stb = 0; e_rd = 0; e_pv = 0;
    n_pins = m_pins; n_dir = m_dir; n_en = m_en;
    if (!is_port(a))        tag = "R9";
    else if (w && sz == 0)  tag = "R8";
    else if (w && sz == 2)  tag = (a == A_PINS) ? "R6" : ((a == A_DIR) ? "R7" : "R9");
    else if (w)             tag = (a == A_PINS) ? "R4" : "R5";
    else if (sz == 2)       tag = "R9";
    else                    tag = !m_en ? "R2" : ((a == A_PINS) ? "R3" : "R10");
    if (is_port(a)) begin
      if (!w && sz != 2) begin
        e_hit = 1; e_rd = exp_read(a);
      end else if (w && sz == 1) begin
        if (a == A_PINS) begin n_pins = wd[3:0] & m_dir; e_stb = 1; e_pv = n_pins; end
        if (a == A_DIR)  n_dir = wd[3:0];
        if (a == A_EN)   n_en = wd[0];
      end else if (w && sz == 2) begin
        if (a == A_PINS) begin
          n_pins = wd[3:0] & m_dir; e_stb = 1; e_pv = n_pins; n_dir = wd[19:16];
        end
        if (a == A_DIR) begin n_dir = wd[3:0]; n_en = wd[16]; end
      end
    end
    acc_valid = 1; acc_write = w; acc_size = sz; acc_addr = a; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0;
    check(tag, "rd_hit", {31'h0, rd_hit}, {31'h0, e_hit});
    check(tag, "rd_data", {16'h0, rd_data}, {16'h0, e_rd});
    check(tag, "pin_stb", {31'h0, pin_stb}, {31'h0, e_stb});
    if (e_stb) check(tag, "pin_val", {28'h0, pin_val}, {28'h0, e_pv});
    m_pins = n_pins; m_dir = n_dir; m_en = n_en;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] pick [8];
    m_pins = 4'h0; m_dir = 4'hF; m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", "rd_hit after reset", {31'h0, rd_hit}, 32'h0);
    check("R1", "pin_stb after reset", {31'h0, pin_stb}, 32'h0);
    // Directed corner cases
    do_op(0, 1, A_DIR, 0);                 // R2 gated read
    do_op(0, 0, A_EN, 0);                  // R2 byte read gated
    do_op(1, 1, A_EN, 32'h1);              // R5 enable on
    do_op(0, 1, A_DIR, 0);                 // R1 reset dir F
    do_op(0, 1, A_PINS, 0);                // R1 pins read 0
    do_op(1, 1, A_PINS, 32'hFFFF_FFFA);    // R4 write A with dir F
    do_op(1, 1, A_DIR, 32'h0);             // R5 all inputs
    do_op(0, 1, A_PINS, 0);                // R3 sees A
    do_op(1, 1, A_PINS, 32'h5);            // R4 masked to 0
    do_op(0, 0, A_PINS, 0);                // R10 byte read
    do_op(1, 2, A_PINS, 32'h000C_0009);    // R6 split, old dir 0
    do_op(0, 1, A_DIR, 0);                 // dir now C
    do_op(1, 2, A_DIR, 32'h0001_0003);     // R7 split
    do_op(1, 0, A_EN, 32'h0);              // R8 byte write ignored
    do_op(0, 1, A_EN, 0);                  // still enabled
    do_op(1, 0, A_DIR, 32'hF);             // R8
    do_op(0, 1, A_DIR, 0);
    do_op(0, 2, A_PINS, 0);                // R9 word read ignored
    do_op(1, 2, A_EN, 32'h0);              // R9 word write at enable ignored
    do_op(1, 1, BASE + 32'hC5, 32'h0);     // R9 odd address
    do_op(1, 1, 32'h0900_00C4, 32'hF);     // R9 foreign region
    do_op(0, 1, A_EN, 0);
    // Random phase, fixed seed
    seed = 32'd12345;
    void'($urandom(seed));
    pick[0] = A_PINS; pick[1] = A_DIR; pick[2] = A_EN; pick[3] = A_PINS;
    pick[4] = BASE + 32'hC5; pick[5] = BASE + 32'hCA; pick[6] = 32'h0900_00C6; pick[7] = A_DIR;
    for (int i = 0; i < 600; i++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 2));
      do_op(1'($urandom_range(0, 1)), sz, pick[$urandom_range(0, 7)], $urandom);
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule